// File: doc/BRIEF.md
# Asymmetric Dual-Port RAM

A true dual-port synchronous RAM. Each row holds sixteen data bits and two parity bits; with the default of 1024 rows that gives 16 Kbit of data and 2 Kbit of parity. Each port has its own clock, active-low asynchronous reset, enable, write enable, synchronous output clear, address, write data and read data. Each port's width is a parameter chosen from 1, 2, 4, 9 or 18 bits. The port's depth follows from that width.

Both ports view the same storage, so data written as narrow words on one side can be read as wide words on the other. A 9-bit or 18-bit port also reaches the parity bits. Tying the most significant address bit of each port to opposite values splits the storage into two halves that work as independent single-port RAMs.

Top module: `adp_ram`

## Requirements
- R1: A port of width W in {1, 2, 4, 9, 18} has data width DW = 1, 2, 4, 8, 16 and parity width PW = 0, 0, 0, 1, 2. It addresses ROWS·16/DW words, which gives 16K×1 down to 1K×18 at the default ROWS = 1024.
- R2: Data mapping is little-endian. Word k of a port covers bits k·DW to k·DW+DW−1 of a flat data space that both ports share. On din and dout, bits [DW−1:0] carry those data bits.
- R3: In the 9-bit and 18-bit widths, bits [W−1:DW] of a word carry parity bits k·PW to k·PW+PW−1 of a shared parity space. The other port's parity view reads the same bits.
- R4: A read with the enable high places the addressed word on dout after the next rising edge of that port's clock.
- R5: While enable is low, dout holds its value and no write takes place, whatever the write enable, address and data are.
- R6: A write with the enable high stores din at the next edge, and dout shows din after that same edge (write-first).
- R7: The output clear, when the enable is high, sets dout to zero at the next edge. It leaves the memory contents unchanged.
- R8: A low reset input clears that port's dout at once. The port resumes operation on the third rising edge after the reset is released.
- R9: When port A's top address bit is held at 0 and port B's at 1, each port reaches only its own half of the data and parity space. Both ports can access their halves in the same cycle.
- R10: Writes from the two ports in the same cycle to different bits of the same row both take effect. Writes from both ports to the same bit in the same cycle leave that bit undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A asynchronous active-low reset of the output |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| srst_a | input | 1 | Port A synchronous output clear |
| addr_a | input | log2(ROWS)+log2(16/DW_A) | Port A word address |
| din_a | input | WIDTH_A | Port A write data, parity in the upper bits |
| dout_a | output | WIDTH_A | Port A registered read data |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B asynchronous active-low reset of the output |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| srst_b | input | 1 | Port B synchronous output clear |
| addr_b | input | log2(ROWS)+log2(16/DW_B) | Port B word address |
| din_b | input | WIDTH_B | Port B write data, parity in the upper bits |
| dout_b | output | WIDTH_B | Port B registered read data |

## Verification
Two small instances are tested: an 18/9-bit pair that includes parity, and a 4/1-bit pair without parity. In each, one side fills every word and the other side reads back every word. The direction is then reversed with a different arithmetic pattern. These sweeps separate the lane and row decoding, so a swapped lane order, a wrong shift or a misplaced parity bit shows up as a mismatch at a specific address.

Further single accesses cover the remaining behaviours:
- enable low while write enable is set, which distinguishes gating from an unconditional write;
- output clear followed by a read, which distinguishes clearing the register from clearing the memory;
- simultaneous writes to opposite halves, and to different bits of one row, which expose any write by one port that disturbs the other port's bits.

// File: rtl/adp_pkg.sv
package adp_pkg;
  localparam int ROW_DBITS = 16;
  localparam int ROW_PBITS = 2;
  localparam int ROW_BITS  = ROW_DBITS + ROW_PBITS;

  function automatic int data_bits(input int w);
    return (w == 18) ? 16 : (w == 9) ? 8 : w;
  endfunction

  function automatic int par_bits(input int w);
    return (w == 18) ? 2 : (w == 9) ? 1 : 0;
  endfunction

  function automatic int addr_bits(input int rows, input int w);
    return $clog2(rows) + $clog2(ROW_DBITS / data_bits(w));
  endfunction
endpackage

// File: rtl/adp_bank.sv
// One storage array with a single clocked writer and two combinational row reads.
module adp_bank
  import adp_pkg::*;
#(
  parameter int ROWS = 1024,
  localparam int RAW = $clog2(ROWS)
)(
  input  logic                clk,
  input  logic                we,
  input  logic [RAW-1:0]      wrow,
  input  logic [ROW_BITS-1:0] wmask,
  input  logic [ROW_BITS-1:0] wval,
  input  logic [RAW-1:0]      rrow0,
  input  logic [RAW-1:0]      rrow1,
  output logic [ROW_BITS-1:0] rdat0,
  output logic [ROW_BITS-1:0] rdat1
);
  logic [ROW_BITS-1:0] mem [ROWS];
  logic [ROW_BITS-1:0] merged;

  assign merged = (mem[wrow] & ~wmask) | (wval & wmask);

  always_ff @(posedge clk) begin
    if (we) mem[wrow] <= merged;
  end

  assign rdat0 = mem[rrow0];
  assign rdat1 = mem[rrow1];
endmodule

// File: rtl/adp_port.sv
// Address decode, lane insertion/extraction and output register of one port.
module adp_port
  import adp_pkg::*;
#(
  parameter int ROWS = 1024,
  parameter int W    = 18,
  localparam int DW    = data_bits(W),
  localparam int PW    = par_bits(W),
  localparam int LANES = ROW_DBITS / DW,
  localparam int LB    = $clog2(LANES),
  localparam int RAW   = $clog2(ROWS),
  localparam int AW    = RAW + LB
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                we,
  input  logic                srst,
  input  logic [AW-1:0]       addr,
  input  logic [W-1:0]        din,
  input  logic [ROW_BITS-1:0] own_row,
  input  logic [ROW_BITS-1:0] other_row,
  output logic [RAW-1:0]      row,
  output logic                bank_we,
  output logic [ROW_BITS-1:0] bank_mask,
  output logic [ROW_BITS-1:0] bank_val,
  output logic [W-1:0]        dout
);
  logic [3:0]           lane;
  int                   dofs;
  int                   pofs;
  logic [ROW_DBITS-1:0] dmask, dins, rd_d;
  logic [ROW_PBITS-1:0] pmask, pins, rd_p;
  logic [ROW_BITS-1:0]  rd_row;
  logic [W-1:0]         rd_word;
  logic [1:0]           rst_q;
  logic                 run;
  logic [W-1:0]         dout_q, dout_nx;

  assign row = addr[AW-1 -: RAW];

  if (LB > 0) begin : g_lane
    assign lane = 4'(addr[LB-1:0]);
  end else begin : g_nolane
    assign lane = '0;
  end

  assign dofs = 32'(lane) * DW;
  assign pofs = 32'(lane) * PW;

  assign dmask  = 16'((1 << DW) - 1) << dofs;
  assign dins   = 16'(din[DW-1:0]) << dofs;
  assign rd_row = own_row ^ other_row;
  assign rd_d   = rd_row[ROW_DBITS-1:0] >> dofs;
  assign rd_p   = rd_row[ROW_BITS-1:ROW_DBITS] >> pofs;

  if (PW > 0) begin : g_par
    assign pmask   = 2'((1 << PW) - 1) << pofs;
    assign pins    = 2'(din[W-1:DW]) << pofs;
    assign rd_word = {rd_p[PW-1:0], rd_d[DW-1:0]};
  end else begin : g_nopar
    assign pmask   = '0;
    assign pins    = '0;
    assign rd_word = rd_d[DW-1:0];
  end

  // Stored value is the XOR of both banks, so this port writes (new ^ other bank).
  assign bank_we   = en & we;
  assign bank_mask = {pmask, dmask};
  assign bank_val  = {pins, dins} ^ other_row;

  logic unused_ok;
  assign unused_ok = ^{rd_d, rd_p};

  // Reset release synchronizer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign run = rst_q[1];

  always_comb begin
    if (srst)    dout_nx = '0;
    else if (we) dout_nx = din;
    else         dout_nx = rd_word;
  end

  always_ff @(posedge clk or negedge run) begin
    if (!run)    dout_q <= '0;
    else if (en) dout_q <= dout_nx;
  end

  assign dout = dout_q;
endmodule

// File: rtl/adp_ram.sv
module adp_ram
  import adp_pkg::*;
#(
  parameter int ROWS    = 1024,
  parameter int WIDTH_A = 18,
  parameter int WIDTH_B = 9,
  localparam int AW_A = addr_bits(ROWS, WIDTH_A),
  localparam int AW_B = addr_bits(ROWS, WIDTH_B)
)(
  input  logic               clk_a,
  input  logic               rst_a_n,
  input  logic               en_a,
  input  logic               we_a,
  input  logic               srst_a,
  input  logic [AW_A-1:0]    addr_a,
  input  logic [WIDTH_A-1:0] din_a,
  output logic [WIDTH_A-1:0] dout_a,
  input  logic               clk_b,
  input  logic               rst_b_n,
  input  logic               en_b,
  input  logic               we_b,
  input  logic               srst_b,
  input  logic [AW_B-1:0]    addr_b,
  input  logic [WIDTH_B-1:0] din_b,
  output logic [WIDTH_B-1:0] dout_b
);
  localparam int RAW = $clog2(ROWS);

  logic [RAW-1:0]      row_a, row_b;
  logic                bwe_a, bwe_b;
  logic [ROW_BITS-1:0] mask_a, mask_b, val_a, val_b;
  logic [ROW_BITS-1:0] ka_ra, ka_rb, kb_ra, kb_rb;

  adp_bank #(.ROWS(ROWS)) u_bank_a (
    .clk(clk_a), .we(bwe_a), .wrow(row_a), .wmask(mask_a), .wval(val_a),
    .rrow0(row_a), .rrow1(row_b), .rdat0(ka_ra), .rdat1(ka_rb)
  );

  adp_bank #(.ROWS(ROWS)) u_bank_b (
    .clk(clk_b), .we(bwe_b), .wrow(row_b), .wmask(mask_b), .wval(val_b),
    .rrow0(row_a), .rrow1(row_b), .rdat0(kb_ra), .rdat1(kb_rb)
  );

  adp_port #(.ROWS(ROWS), .W(WIDTH_A)) u_port_a (
    .clk(clk_a), .rst_n(rst_a_n), .en(en_a), .we(we_a), .srst(srst_a),
    .addr(addr_a), .din(din_a), .own_row(ka_ra), .other_row(kb_ra),
    .row(row_a), .bank_we(bwe_a), .bank_mask(mask_a), .bank_val(val_a),
    .dout(dout_a)
  );

  adp_port #(.ROWS(ROWS), .W(WIDTH_B)) u_port_b (
    .clk(clk_b), .rst_n(rst_b_n), .en(en_b), .we(we_b), .srst(srst_b),
    .addr(addr_b), .din(din_b), .own_row(kb_rb), .other_row(ka_rb),
    .row(row_b), .bank_we(bwe_b), .bank_mask(mask_b), .bank_val(val_b),
    .dout(dout_b)
  );
endmodule

// File: rtl/adp_ram_chk.sv
module adp_ram_chk #(
  parameter int WA  = 18,
  parameter int WB  = 9,
  parameter int AWA = 10,
  parameter int AWB = 11
)(
  input logic           clk_a,
  input logic           rst_a_n,
  input logic           en_a,
  input logic           we_a,
  input logic           srst_a,
  input logic [AWA-1:0] addr_a,
  input logic [WA-1:0]  din_a,
  input logic [WA-1:0]  dout_a,
  input logic           clk_b,
  input logic           rst_b_n,
  input logic           en_b,
  input logic           we_b,
  input logic           srst_b,
  input logic [AWB-1:0] addr_b,
  input logic [WB-1:0]  din_b,
  input logic [WB-1:0]  dout_b
);
  logic [1:0] age_a, age_b;

  always_ff @(posedge clk_a or negedge rst_a_n) begin
    if (!rst_a_n)          age_a <= 2'd0;
    else if (age_a != 2'd3) age_a <= age_a + 2'd1;
  end

  always_ff @(posedge clk_b or negedge rst_b_n) begin
    if (!rst_b_n)          age_b <= 2'd0;
    else if (age_b != 2'd3) age_b <= age_b + 2'd1;
  end

  logic unused_ok;
  assign unused_ok = ^{addr_a, addr_b};

  assert_hold_a_R5: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    !en_a |=> $stable(dout_a));
  assert_hold_b_R5: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    !en_b |=> $stable(dout_b));

  assert_wfirst_a_R6: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (age_a >= 2'd2 && en_a && we_a && !srst_a) |=> dout_a == $past(din_a));
  assert_wfirst_b_R6: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (age_b >= 2'd2 && en_b && we_b && !srst_b) |=> dout_b == $past(din_b));

  assert_clear_a_R7: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (en_a && srst_a) |=> dout_a == '0);
  assert_clear_b_R7: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (en_b && srst_b) |=> dout_b == '0);

  always_comb begin
    if (!rst_a_n) assert_rst_a_R8: assert (dout_a == '0);
    if (!rst_b_n) assert_rst_b_R8: assert (dout_b == '0);
  end
endmodule

bind adp_ram adp_ram_chk #(.WA(WIDTH_A), .WB(WIDTH_B), .AWA(AW_A), .AWB(AW_B)) u_chk (
  .clk_a(clk_a), .rst_a_n(rst_a_n), .en_a(en_a), .we_a(we_a), .srst_a(srst_a),
  .addr_a(addr_a), .din_a(din_a), .dout_a(dout_a),
  .clk_b(clk_b), .rst_b_n(rst_b_n), .en_b(en_b), .we_b(we_b), .srst_b(srst_b),
  .addr_b(addr_b), .din_b(din_b), .dout_b(dout_b)
);

// File: tb/tb_adp_ram.sv
module tb_adp_ram;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  // dut: 16 rows, A = 18-bit x 16, B = 9-bit x 32
  logic a_en = 0, a_we = 0, a_sr = 0; logic [3:0] a_ad = '0; logic [17:0] a_di = '0; logic [17:0] a_do;
  logic b_en = 0, b_we = 0, b_sr = 0; logic [4:0] b_ad = '0; logic [8:0]  b_di = '0; logic [8:0]  b_do;
  // dut2: 16 rows, C = 4-bit x 64, D = 1-bit x 256
  logic c_en = 0, c_we = 0, c_sr = 0; logic [5:0] c_ad = '0; logic [3:0]  c_di = '0; logic [3:0]  c_do;
  logic d_en = 0, d_we = 0, d_sr = 0; logic [7:0] d_ad = '0; logic [0:0]  d_di = '0; logic [0:0]  d_do;

  adp_ram #(.ROWS(16), .WIDTH_A(18), .WIDTH_B(9)) dut (
    .clk_a(clk), .rst_a_n(rst_n), .en_a(a_en), .we_a(a_we), .srst_a(a_sr),
    .addr_a(a_ad), .din_a(a_di), .dout_a(a_do),
    .clk_b(clk), .rst_b_n(rst_n), .en_b(b_en), .we_b(b_we), .srst_b(b_sr),
    .addr_b(b_ad), .din_b(b_di), .dout_b(b_do));

  adp_ram #(.ROWS(16), .WIDTH_A(4), .WIDTH_B(1)) dut2 (
    .clk_a(clk), .rst_a_n(rst_n), .en_a(c_en), .we_a(c_we), .srst_a(c_sr),
    .addr_a(c_ad), .din_a(c_di), .dout_a(c_do),
    .clk_b(clk), .rst_b_n(rst_n), .en_b(d_en), .we_b(d_we), .srst_b(d_sr),
    .addr_b(d_ad), .din_b(d_di), .dout_b(d_do));

  int nchk = 0, nfail = 0;
  bit done = 0;
  bit dm [256];
  bit pm [32];

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] expw(input int dw, input int pw, input int k);
    logic [17:0] r = '0;
    for (int i = 0; i < dw; i++) r[i] = dm[k*dw+i];
    for (int j = 0; j < pw; j++) r[dw+j] = pm[k*pw+j];
    return r;
  endfunction

  function automatic void updw(input int dw, input int pw, input int k, input logic [17:0] v);
    for (int i = 0; i < dw; i++) dm[k*dw+i] = v[i];
    for (int j = 0; j < pw; j++) pm[k*pw+j] = v[dw+j];
  endfunction

  task automatic pa(input bit we, input int ad, input int v);
    @(negedge clk); a_en = 1; a_we = we; a_ad = 4'(ad); a_di = 18'(v);
    @(negedge clk); a_en = 0; a_we = 0;
  endtask
  task automatic pb(input bit we, input int ad, input int v);
    @(negedge clk); b_en = 1; b_we = we; b_ad = 5'(ad); b_di = 9'(v);
    @(negedge clk); b_en = 0; b_we = 0;
  endtask
  task automatic pc(input bit we, input int ad, input int v);
    @(negedge clk); c_en = 1; c_we = we; c_ad = 6'(ad); c_di = 4'(v);
    @(negedge clk); c_en = 0; c_we = 0;
  endtask
  task automatic pd(input bit we, input int ad, input int v);
    @(negedge clk); d_en = 1; d_we = we; d_ad = 8'(ad); d_di = 1'(v);
    @(negedge clk); d_en = 0; d_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [17:0] v, va, vb, keep;
    repeat (3) @(negedge clk);
    chk("R8 reset dout_a", a_do, 18'h0);
    chk("R8 reset dout_b", 18'(b_do), 18'h0);
    chk("R8 reset dout_c", 18'(c_do), 18'h0);
    chk("R8 reset dout_d", 18'(d_do), 18'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R8 after release dout_a", a_do, 18'h0);

    // R1 R2 R3: fill through the 18-bit port, read all through the 9-bit port
    for (int k = 0; k < 16; k++) begin
      v = 18'((k * 32'h0B5A3 + 32'h2C1D7) & 32'h3FFFF);
      pa(1, k, v);
      chk("R6 write-first A18", a_do, v);
      updw(16, 2, k, v);
    end
    for (int k = 0; k < 32; k++) begin
      pb(0, k, 0);
      chk("R2 R3 R4 read B9", 18'(b_do), expw(8, 1, k));
    end
    // reverse direction
    for (int k = 0; k < 32; k++) begin
      v = 18'(((k * 32'h0A7) ^ 32'h15A) & 32'h1FF);
      pb(1, k, v);
      chk("R6 write-first B9", 18'(b_do), v);
      updw(8, 1, k, v);
    end
    for (int k = 0; k < 16; k++) begin
      pa(0, k, 0);
      chk("R1 R2 R3 read A18", a_do, expw(16, 2, k));
    end

    // R5: enable low blocks write and holds output
    pa(0, 3, 0);
    keep = a_do;
    @(negedge clk); a_en = 0; a_we = 1; a_ad = 4'd5; a_di = ~expw(16, 2, 5);
    @(negedge clk); a_we = 0;
    chk("R5 dout held while disabled", a_do, keep);
    pa(0, 5, 0);
    chk("R5 no write while disabled", a_do, expw(16, 2, 5));

    // R7: output clear leaves memory intact
    pa(0, 7, 0);
    @(negedge clk); a_en = 1; a_sr = 1; a_we = 0;
    @(negedge clk); a_en = 0; a_sr = 0;
    chk("R7 output cleared", a_do, 18'h0);
    pa(0, 7, 0);
    chk("R7 memory unchanged", a_do, expw(16, 2, 7));

    // R9: A in lower half (top bit 0), B in upper half (top bit 1), same cycle
    va = 18'h2A5C3; vb = 18'h0013C;
    @(negedge clk);
    a_en = 1; a_we = 1; a_ad = 4'd2;  a_di = va;
    b_en = 1; b_we = 1; b_ad = 5'd25; b_di = 9'(vb);
    @(negedge clk);
    a_en = 0; a_we = 0; b_en = 0; b_we = 0;
    chk("R9 A write-first", a_do, va);
    chk("R9 B write-first", 18'(b_do), vb);
    updw(16, 2, 2, va);
    updw(8, 1, 25, vb);
    pa(0, 12, 0);
    chk("R9 B landed in upper half", a_do, expw(16, 2, 12));
    pb(0, 4, 0);
    chk("R9 A landed in lower half lo", 18'(b_do), expw(8, 1, 4));
    pb(0, 5, 0);
    chk("R9 A landed in lower half hi", 18'(b_do), expw(8, 1, 5));
    pa(0, 2, 0);
    chk("R9 A word intact", a_do, expw(16, 2, 2));

    // dut2: 4-bit and 1-bit views, no parity
    for (int k = 0; k < 32; k++) pm[k] = 0;
    for (int k = 0; k < 256; k++) begin
      v = 18'((((k * 37) >> 2) ^ k) & 1);
      pd(1, k, v);
      chk("R6 write-first D1", 18'(d_do), v);
      updw(1, 0, k, v);
    end
    for (int k = 0; k < 64; k++) begin
      pc(0, k, 0);
      chk("R2 read C4", 18'(c_do), expw(4, 0, k));
    end
    for (int k = 0; k < 64; k++) begin
      v = 18'((k * 7 + 3) & 15);
      pc(1, k, v);
      updw(4, 0, k, v);
    end
    for (int k = 0; k < 256; k++) begin
      pd(0, k, 0);
      chk("R1 R2 read D1", 18'(d_do), expw(1, 0, k));
    end

    // R10: same row, different bits, same cycle
    @(negedge clk);
    c_en = 1; c_we = 1; c_ad = 6'd8;  c_di = ~4'(expw(4, 0, 8));
    d_en = 1; d_we = 1; d_ad = 8'd47; d_di = ~1'(expw(1, 0, 47));
    @(negedge clk);
    c_en = 0; c_we = 0; d_en = 0; d_we = 0;
    updw(4, 0, 8, ~expw(4, 0, 8) & 18'hF);
    updw(1, 0, 47, ~expw(1, 0, 47) & 18'h1);
    pc(0, 8, 0);
    chk("R10 C lane kept", 18'(c_do), expw(4, 0, 8));
    pc(0, 11, 0);
    chk("R10 D bit kept", 18'(c_do), expw(4, 0, 11));
    pd(0, 33, 0);
    chk("R10 D view of C write", 18'(d_do), expw(1, 0, 33));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule